// File: doc/BRIEF.md
# Transactional Directory Mark Handler

This block sits on the directory side of a chip multiprocessor that runs hardware transactions. A core inside a transaction sends a mark request to this handler in place of a plain shared or exclusive fetch. The handler keeps one sharer bit per core for each of a small fixed set of lines. For every mark it answers the requester with an acknowledgement. That acknowledgement carries the line and how many other cores hold the line. The handler then sends an accessor notice to each of those other cores, naming the requester and the line. Each core can then record a possible conflict as soon as it occurs rather than at commit.

The same port also carries commit write-backs and releases. A commit is an ordinary write that leaves the committer as the only holder of the line. Commits to different lines need no ordering between them. A release removes the core from the sharer set. Request, acknowledgement and accessor channels each use a valid/ready handshake. A request naming an untracked line, or using the reserved kind, raises a one-cycle error flag and produces no messages.

Top module: `txdir_mark_ctrl`

## Requirements
- R1: A mark request (kind 0) is acknowledged exactly once to the requesting core, echoing the line. The count equals the number of cores other than the requester whose sharer bit is set for that line, and is 0 when no other core holds it.
- R2: After a mark, the requester's bit is set in that line's sharer set. A repeated mark by the same core does not count the core itself.
- R3: A mark sends one accessor notice to every other sharer, and to no other core. Each notice carries the requester's core number and the line. The notices are delivered one per accepted handshake in ascending destination order.
- R4: After an operation is accepted, req_ready stays low until its acknowledgement has been taken and all of its accessor notices have been taken.
- R5: A release request (kind 1) clears the requester's sharer bit, returns an acknowledgement with count 0, and sends no accessor notices.
- R6: A commit request (kind 2) returns an acknowledgement whose count is the number of other sharers at that moment. It sends no accessor notices, and it leaves the committer as the line's only sharer.
- R7: A request to a line number at or above NLINES, or with kind 3, pulses err for one cycle in the cycle after acceptance. Such a request produces no acknowledgement and no accessor notice, and changes no sharer set.
- R8: While ack_valid or acc_valid is high and its ready is low, that channel's valid and payload hold steady.
- R9: Reset empties every sharer set, drops ack_valid, acc_valid and err, and raises req_ready.
- R10: Operations on one line leave every other line's sharer set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Handler can accept a request |
| req_kind | input | 2 | 0 mark, 1 release, 2 commit, 3 reserved |
| req_core | input | CORE_W | Requesting core number |
| req_line | input | LINE_W | Line number |
| ack_valid | output | 1 | Acknowledgement present |
| ack_ready | input | 1 | Acknowledgement taken |
| ack_core | output | CORE_W | Destination core of the acknowledgement |
| ack_line | output | LINE_W | Line being acknowledged |
| ack_count | output | CNT_W | Number of other sharers |
| acc_valid | output | 1 | Accessor notice present |
| acc_ready | input | 1 | Accessor notice taken |
| acc_dest | output | CORE_W | Core receiving the notice |
| acc_src | output | CORE_W | Core that issued the mark |
| acc_line | output | LINE_W | Line that was marked |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The embedded assertions check several properties on every cycle. Each stalled channel must hold its valid and payload. Accessor notices must go out in ascending order and never back to the requester. A release must always acknowledge with count zero. A valid acceptance must block further requests for the next cycle. An error cycle must never start a message. Only the directed scenarios can show the values that depend on history. These are the exact sharer counts after mixed sequences of marks, releases and commits. They also include the exact set of notified cores, the fact that a rejected request leaves the sharer sets untouched, and the independence of different lines.

// File: rtl/txdir_pkg.sv
package txdir_pkg;

    typedef enum logic [1:0] {
        TXK_MARK    = 2'd0,
        TXK_RELEASE = 2'd1,
        TXK_COMMIT  = 2'd2,
        TXK_RSVD    = 2'd3
    } txkind_e;

    // operation is legal only for tracked lines and defined kinds
    function automatic logic op_is_legal(input txkind_e k, input logic in_range);
        return in_range && (k != TXK_RSVD);
    endfunction

endpackage

// File: rtl/txdir_sharer_tab.sv
module txdir_sharer_tab #(
    parameter int NCORES = 32,
    parameter int NLINES = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [NCORES-1:0] rd_vec,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [NCORES-1:0] wr_vec
);

    logic [NCORES-1:0] tab_q [NLINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLINES; i++) tab_q[i] <= '0;
        end else if (wr_en) begin
            tab_q[wr_idx] <= wr_vec;
        end
    end

    assign rd_vec = tab_q[rd_idx];

endmodule

// File: rtl/txdir_fanout.sv
module txdir_fanout #(
    parameter int NCORES = 32,
    parameter int CORE_W = 5,
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [NCORES-1:0] load_mask,
    input  logic [CORE_W-1:0] load_src,
    input  logic [LINE_W-1:0] load_line,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CORE_W-1:0] out_dest,
    output logic [CORE_W-1:0] out_src,
    output logic [LINE_W-1:0] out_line
);

    logic [NCORES-1:0] pend_q;
    logic [CORE_W-1:0] src_q;
    logic [LINE_W-1:0] line_q;
    logic [CORE_W-1:0] sel;
    logic              found;

    // lowest pending core goes first
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < NCORES; i++) begin
            if (pend_q[i] && !found) begin
                sel   = CORE_W'(i);
                found = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            src_q  <= '0;
            line_q <= '0;
        end else if (load) begin
            pend_q <= load_mask;
            src_q  <= load_src;
            line_q <= load_line;
        end else if (out_valid && out_ready) begin
            pend_q[sel] <= 1'b0;
        end
    end

    assign out_valid = |pend_q;
    assign out_dest  = sel;
    assign out_src   = src_q;
    assign out_line  = line_q;

    // R3
    ascending_order_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (!out_valid || (out_dest > $past(out_dest))));

    // R3
    no_self_notice_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_dest != out_src));

    // R8
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_dest)
                                       && $stable(out_src) && $stable(out_line)));

endmodule

// File: rtl/txdir_mark_ctrl.sv
module txdir_mark_ctrl
    import txdir_pkg::*;
#(
    parameter int NCORES = 32,
    parameter int NLINES = 8,
    parameter int LINE_W = 8,
    localparam int CORE_W = $clog2(NCORES),
    localparam int IDX_W  = $clog2(NLINES),
    localparam int CNT_W  = $clog2(NCORES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [CORE_W-1:0] req_core,
    input  logic [LINE_W-1:0] req_line,
    output logic              ack_valid,
    input  logic              ack_ready,
    output logic [CORE_W-1:0] ack_core,
    output logic [LINE_W-1:0] ack_line,
    output logic [CNT_W-1:0]  ack_count,
    output logic              acc_valid,
    input  logic              acc_ready,
    output logic [CORE_W-1:0] acc_dest,
    output logic [CORE_W-1:0] acc_src,
    output logic [LINE_W-1:0] acc_line,
    output logic              err
);

    typedef struct packed {
        logic [CORE_W-1:0] core;
        logic [LINE_W-1:0] line;
        logic [CNT_W-1:0]  count;
    } ack_msg_t;

    txkind_e           kind;
    logic              in_range;
    logic              legal;
    logic              req_fire;
    logic [IDX_W-1:0]  idx;
    logic [NCORES-1:0] cur_vec;
    logic [NCORES-1:0] self_vec;
    logic [NCORES-1:0] others;
    logic [NCORES-1:0] next_vec;
    logic [CNT_W-1:0]  cnt;
    logic              tab_wr;
    logic              fan_load;

    ack_msg_t          ack_q;
    logic              ack_v_q;
    logic              err_q;

    assign kind     = txkind_e'(req_kind);
    assign in_range = (32'(req_line) < NLINES);
    assign legal    = op_is_legal(kind, in_range);
    assign req_fire = req_valid && req_ready;
    assign idx      = req_line[IDX_W-1:0];
    assign self_vec = {{(NCORES-1){1'b0}}, 1'b1} << req_core;
    assign others   = cur_vec & ~self_vec;

    always_comb begin
        next_vec = cur_vec;
        cnt      = '0;
        case (kind)
            TXK_MARK: begin
                next_vec = cur_vec | self_vec;
                cnt      = CNT_W'($countones(others));
            end
            TXK_RELEASE: next_vec = cur_vec & ~self_vec;
            TXK_COMMIT: begin
                next_vec = self_vec;
                cnt      = CNT_W'($countones(others));
            end
            default: next_vec = cur_vec;
        endcase
    end

    assign tab_wr   = req_fire && legal;
    assign fan_load = tab_wr && (kind == TXK_MARK);

    txdir_sharer_tab #(
        .NCORES(NCORES), .NLINES(NLINES), .IDX_W(IDX_W)
    ) u_tab (
        .clk(clk), .rst(rst),
        .rd_idx(idx), .rd_vec(cur_vec),
        .wr_en(tab_wr), .wr_idx(idx), .wr_vec(next_vec)
    );

    txdir_fanout #(
        .NCORES(NCORES), .CORE_W(CORE_W), .LINE_W(LINE_W)
    ) u_fan (
        .clk(clk), .rst(rst),
        .load(fan_load), .load_mask(others),
        .load_src(req_core), .load_line(req_line),
        .out_valid(acc_valid), .out_ready(acc_ready),
        .out_dest(acc_dest), .out_src(acc_src), .out_line(acc_line)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_v_q <= 1'b0;
            ack_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= req_fire && !legal;
            if (tab_wr) begin
                ack_v_q    <= 1'b1;
                ack_q.core <= req_core;
                ack_q.line <= req_line;
                ack_q.count <= cnt;
            end else if (ack_v_q && ack_ready) begin
                ack_v_q <= 1'b0;
            end
        end
    end

    assign req_ready = !ack_v_q && !acc_valid;
    assign ack_valid = ack_v_q;
    assign ack_core  = ack_q.core;
    assign ack_line  = ack_q.line;
    assign ack_count = ack_q.count;
    assign err       = err_q;

    // R4
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_fire && legal) |=> !req_ready);

    // R5
    release_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_fire && legal && kind == TXK_RELEASE) |=> (ack_valid && ack_count == '0));

    // R7
    err_silent_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (!$rose(ack_valid) && !$rose(acc_valid)));

    // R8
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !ack_ready) |=> (ack_valid && $stable(ack_count)
                                       && $stable(ack_line) && $stable(ack_core)));

endmodule

// File: tb/txdir_mark_ctrl_tb.sv
module txdir_mark_ctrl_tb;

    localparam int NC = 32;
    localparam int NL = 8;
    localparam int K_MARK = 0;
    localparam int K_REL  = 1;
    localparam int K_COM  = 2;
    localparam int K_RSV  = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_kind = '0;
    logic [4:0] req_core = '0;
    logic [7:0] req_line = '0;
    logic       ack_valid;
    logic       ack_ready = 1'b1;
    logic [4:0] ack_core;
    logic [7:0] ack_line;
    logic [5:0] ack_count;
    logic       acc_valid;
    logic       acc_ready = 1'b1;
    logic [4:0] acc_dest;
    logic [4:0] acc_src;
    logic [7:0] acc_line;
    logic       err;

    txdir_mark_ctrl u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_core(req_core), .req_line(req_line),
        .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_core(ack_core),
        .ack_line(ack_line), .ack_count(ack_count),
        .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_dest(acc_dest),
        .acc_src(acc_src), .acc_line(acc_line), .err(err)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    bit stall = 1'b0;

    logic [NC-1:0] mdl [NL];

    // observations of one operation
    bit saw_err, err_late, ready_bad, hold_bad, src_bad;
    int ack_n, got_cnt, got_line, got_core, acc_n;
    int acc_list [64];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input int kind, input int core, input int line);
        bit prev_stall;
        int prev_dest;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_kind  = 2'(kind);
        req_core  = 5'(core);
        req_line  = 8'(line);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        saw_err = err;
        err_late = 0; ready_bad = 0; hold_bad = 0; src_bad = 0;
        ack_n = 0; acc_n = 0; got_cnt = -1; got_line = -1; got_core = -1;
        prev_stall = 0; prev_dest = 0;
        for (int it = 0; it < 200; it++) begin
            if (!ack_valid && !acc_valid && req_ready) break;
            if (it > 0 && err) err_late = 1;
            if ((ack_valid || acc_valid) && req_ready) ready_bad = 1;
            if (prev_stall && !(acc_valid && int'(acc_dest) == prev_dest)) hold_bad = 1;
            acc_ready = stall ? (it % 2 == 1) : 1'b1;
            #1;
            if (ack_valid && ack_ready) begin
                ack_n++;
                got_cnt = int'(ack_count);
                got_line = int'(ack_line);
                got_core = int'(ack_core);
            end
            if (acc_valid && acc_ready) begin
                if (acc_n < 64) acc_list[acc_n] = int'(acc_dest);
                acc_n++;
                if (int'(acc_src) != core || int'(acc_line) != line) src_bad = 1;
            end
            prev_stall = acc_valid && !acc_ready;
            prev_dest  = int'(acc_dest);
            @(negedge clk);
        end
        acc_ready = 1'b1;
    endtask

    task automatic do_op(input int kind, input int core, input int line, input string tag);
        bit legal;
        logic [NC-1:0] oth;
        int exp_cnt, exp_n, k;
        legal = (line < NL) && (kind != K_RSV);
        oth = legal ? (mdl[line] & ~(NC'(1) << core)) : '0;
        exp_cnt = (kind == K_MARK || kind == K_COM) ? $countones(oth) : 0;
        exp_n = (kind == K_MARK) ? $countones(oth) : 0;
        send(kind, core, line);
        chk(saw_err == !legal, {tag, " err flag"}, int'(saw_err), int'(!legal));
        chk(!err_late, {tag, " err one cycle"}, int'(err_late), 0);
        if (!legal) begin
            chk(ack_n == 0, {tag, " no ack"}, ack_n, 0);
            chk(acc_n == 0, {tag, " no notice"}, acc_n, 0);
            return;
        end
        chk(ack_n == 1, {tag, " ack once"}, ack_n, 1);
        chk(got_cnt == exp_cnt, {tag, " count"}, got_cnt, exp_cnt);
        chk(got_line == line && got_core == core, {tag, " ack addr"}, got_line, line);
        chk(acc_n == exp_n, {tag, " notice n"}, acc_n, exp_n);
        k = 0;
        for (int c = 0; c < NC; c++) begin
            if (kind == K_MARK && oth[c] && k < acc_n) begin
                chk(acc_list[k] == c, {tag, " R3 notice order"}, acc_list[k], c);
                k++;
            end
        end
        chk(!src_bad, {tag, " R3 notice payload"}, int'(src_bad), 0);
        chk(!ready_bad, {tag, " R4 ready low"}, int'(ready_bad), 0);
        chk(!hold_bad, {tag, " R8 hold"}, int'(hold_bad), 0);
        case (kind)
            K_MARK: mdl[line] = mdl[line] | (NC'(1) << core);
            K_REL:  mdl[line] = mdl[line] & ~(NC'(1) << core);
            K_COM:  mdl[line] = NC'(1) << core;
            default: ;
        endcase
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R9 ready", int'(req_ready), 1);
        chk(!ack_valid && !acc_valid, "R9 valids", int'(ack_valid), 0);
        chk(err == 1'b0, "R9 err", int'(err), 0);
    endtask

    task automatic t_mark_basic();
        do_op(K_MARK, 0, 3, "R1 first mark");
        do_op(K_MARK, 2, 3, "R1 second mark");
        do_op(K_MARK, 0, 3, "R2 repeat mark");
    endtask

    task automatic t_fanout_stall();
        do_op(K_MARK, 7, 5, "R3 setup");
        do_op(K_MARK, 30, 5, "R3 setup");
        do_op(K_MARK, 1, 5, "R3 setup");
        stall = 1'b1;
        do_op(K_MARK, 4, 5, "R3 fanout stalled");
        stall = 1'b0;
    endtask

    task automatic t_release();
        do_op(K_REL, 2, 3, "R5 release");
        do_op(K_MARK, 9, 3, "R5 after release");
    endtask

    task automatic t_commit();
        do_op(K_COM, 1, 5, "R6 commit");
        do_op(K_MARK, 12, 5, "R6 after commit");
    endtask

    task automatic t_reject();
        do_op(K_MARK, 6, 8, "R7 line at limit");
        do_op(K_COM, 6, 200, "R7 far line");
        do_op(K_RSV, 6, 3, "R7 reserved kind");
        do_op(K_MARK, 20, 3, "R7 state untouched");
    endtask

    task automatic t_indep();
        do_op(K_MARK, 3, 6, "R10 fresh line");
        do_op(K_MARK, 3, 0, "R10 other line");
        do_op(K_MARK, 31, 5, "R10 line five intact");
    endtask

    task automatic t_ack_stall();
        ack_ready = 1'b0;
        fork
            begin
                repeat (4) @(negedge clk);
                ack_ready = 1'b1;
            end
        join_none
        do_op(K_MARK, 5, 6, "R8 ack stalled");
        ack_ready = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mark_basic();
        t_fanout_stall();
        t_release();
        t_commit();
        t_reject();
        t_indep();
        t_ack_stall();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule